// File: doc/BRIEF.md
# Credit-Tracking DMA Burst Scheduler

This block sits inside a DMA master and decides, channel by channel, when a burst may be sent to or fetched from a peripheral FIFO. The peripheral gives no threshold request. It only pulses once per word that it moves on its far side. The scheduler keeps an occupancy count for each channel. It compares that count against a programmed copy of the peripheral's FIFO depth and the programmed burst length.

A playback channel (memory to peripheral) counts words that are sitting in the peripheral FIFO. Each granted burst adds the burst length, and each word pulse removes one word. The channel asks for a burst once the inferred free space can hold a whole burst. A capture channel (peripheral to memory) counts words waiting to be collected. Each word pulse adds one, and each granted burst removes the burst length. The channel asks for a burst once a whole burst is waiting.

When several channels are eligible, a round-robin arbiter picks one. Only one burst is outstanding at a time: the burst engine reports the end of it on `burst_done`. The programmed depth must equal the real peripheral depth. A larger value over-issues and overruns the FIFO. A smaller value holds bursts back while room exists, and the stream underruns.

Top module: `burst_sched`

## Requirements
- R1: An enabled playback channel (direction bit 0) with a non-zero burst length raises its `burst_req` bit exactly when depth minus count (zero if the count exceeds the depth) is at least the burst length.
- R2: For a playback channel, the edge that issues a grant to it adds the burst length to its count, and each `word_evt` pulse at that edge subtracts one. Both apply together.
- R3: A playback `word_evt` pulse that would take the count below zero leaves it at zero and sets that channel's `ch_err` bit. The bit stays set until the channel is disabled.
- R4: For a capture channel (direction bit 1), each `word_evt` pulse adds one and a grant subtracts the burst length. `burst_req` is high exactly when the channel is enabled, the burst length is non-zero and the count is at least the burst length.
- R5: A capture `word_evt` pulse that arrives when the count (after any grant at the same edge) already equals the programmed depth leaves the count unchanged and sets `ch_err` (sticky).
- R6: If `busy` is low and any request is high at a clock edge, then after that edge `grant_valid` is high for one cycle, `busy` is high, and the channel's count has been updated. `busy` stays high until an edge with `burst_done` high. No grant is issued while `busy` is high.
- R7: The grant goes to the first requesting channel found by searching upward, with wrap-around, from the channel after the last one granted. After reset the search starts at channel 0. `grant_idx` is the binary channel number and holds its value until the next grant.
- R8: A disabled channel never requests. One edge after it is disabled, its count and its `ch_err` bit are zero.
- R9: With a programmed depth larger than the real FIFO depth, the scheduler issues more words than the FIFO can hold. With depth 24, burst 8 and no drain, it issues three bursts into a 16-word FIFO.
- R10: With a programmed depth smaller than the real depth, bursts are withheld. With depth 8 and burst 8, one burst is issued and then the request stays low, even though a 16-word FIFO still has 8 free words.
- R11: While reset is held and just after it is released, `burst_req`, `grant_valid`, `busy` and `ch_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | NUM_CH | Per-channel enable |
| ch_dir | input | NUM_CH | Per-channel direction: 0 playback, 1 capture |
| ch_depth | input | NUM_CH*CNT_W | Programmed peripheral FIFO depth, channel c at bits c*CNT_W upward |
| ch_blen | input | NUM_CH*CNT_W | Burst length in words, same packing |
| word_evt | input | NUM_CH | One-cycle pulse per word moved on the peripheral's far side |
| burst_done | input | 1 | End of the outstanding burst |
| burst_req | output | NUM_CH | Channel is eligible for a burst |
| grant_valid | output | 1 | One-cycle pulse: a burst was granted |
| grant_idx | output | IDX_W | Channel of the latest grant |
| busy | output | 1 | A burst is outstanding |
| ch_err | output | NUM_CH | Sticky count underflow or overflow per channel |

## Verification
The assertions assume three things about the inputs. Depth, burst length and direction of a channel change only while that channel is disabled, or in the same cycle it is disabled. `burst_done` is meaningful only while `busy` is high. `word_evt` is one bit per channel per cycle. The bench changes configuration only in disable steps, drives `burst_done` only while its model has a burst outstanding, and draws per-channel word pulses at random, including pulses at empty and full counts that deliberately provoke the error flags. The directed phases then check the arbitration order and the two depth mismatch cases.

// File: rtl/bsched_pkg.sv
package bsched_pkg;
   typedef enum logic {
      DIR_PLAY = 1'b0,
      DIR_CAP  = 1'b1
   } xfer_dir_e;
endpackage

// File: rtl/bsched_credit.sv
module bsched_credit
   import bsched_pkg::*;
#(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             dir,
   input  logic [CNT_W-1:0] depth,
   input  logic [CNT_W-1:0] blen,
   input  logic             evt,
   input  logic             take,
   output logic             req,
   output logic             err
);
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             err_q, err_d;
   logic [CNT_W:0]   wide;
   logic [CNT_W:0]   room;

   always_comb begin
      cnt_d = cnt_q;
      err_d = err_q;
      wide  = {1'b0, cnt_q};
      if (!en) begin
         cnt_d = '0;
         err_d = 1'b0;
      end else if (xfer_dir_e'(dir) == DIR_PLAY) begin
         if (take) wide = wide + {1'b0, blen};
         if (evt) begin
            if (wide == '0) err_d = 1'b1;
            else            wide  = wide - 1'b1;
         end
         cnt_d = wide[CNT_W-1:0];
      end else begin
         if (take) wide = wide - {1'b0, blen};
         if (evt) begin
            if (wide >= {1'b0, depth}) err_d = 1'b1;
            else                       wide  = wide + 1'b1;
         end
         cnt_d = wide[CNT_W-1:0];
      end
   end

   always_comb begin
      room = ({1'b0, depth} > {1'b0, cnt_q}) ? ({1'b0, depth} - {1'b0, cnt_q}) : '0;
      if (!en || blen == '0)
         req = 1'b0;
      else if (xfer_dir_e'(dir) == DIR_PLAY)
         req = (room >= {1'b0, blen});
      else
         req = (cnt_q >= blen);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         err_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         err_q <= err_d;
      end
   end

   assign err = err_q;

   // R1 R4: the count never leaves the programmed window while enabled
   assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> cnt_q <= depth);
   // R8: disabling clears count and error
   assert_disable_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en) |-> (cnt_q == '0 && !err_q));
   // R3 R5: the error flag only rises after a word pulse
   assert_err_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> $past(evt));
endmodule

// File: rtl/bsched_rr.sv
module bsched_rr #(
   parameter int NUM_CH = 4,
   localparam int IDX_W = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] req,
   input  logic              adv,
   output logic [IDX_W-1:0]  sel,
   output logic              any
);
   logic [IDX_W-1:0] last_q;

   always_comb begin
      sel = '0;
      any = 1'b0;
      for (int k = 1; k <= NUM_CH; k++) begin
         int idx;
         idx = (int'(last_q) + k) % NUM_CH;
         if (!any && req[idx]) begin
            any = 1'b1;
            sel = IDX_W'(idx);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   last_q <= IDX_W'(NUM_CH - 1);
      else if (adv) last_q <= sel;
   end

   // R7: the chosen channel is always a requesting one
   assert_sel_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> req[sel]);
endmodule

// File: rtl/burst_sched.sv
module burst_sched #(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = 6,
   localparam int IDX_W = $clog2(NUM_CH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_CH-1:0]       ch_en,
   input  logic [NUM_CH-1:0]       ch_dir,
   input  logic [NUM_CH*CNT_W-1:0] ch_depth,
   input  logic [NUM_CH*CNT_W-1:0] ch_blen,
   input  logic [NUM_CH-1:0]       word_evt,
   input  logic                    burst_done,
   output logic [NUM_CH-1:0]       burst_req,
   output logic                    grant_valid,
   output logic [IDX_W-1:0]        grant_idx,
   output logic                    busy,
   output logic [NUM_CH-1:0]       ch_err
);
   if (NUM_CH < 2) begin : g_bad_ch
      $error("burst_sched: NUM_CH must be at least 2");
   end
   if (CNT_W < 2) begin : g_bad_w
      $error("burst_sched: CNT_W must be at least 2");
   end

   logic                 busy_q, gv_q, issue, any;
   logic [IDX_W-1:0]     sel, gidx_q;
   logic [NUM_CH-1:0]    take;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign take[c] = issue && (sel == IDX_W'(c));
      bsched_credit #(.CNT_W(CNT_W)) u_credit (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (ch_en[c]),
         .dir   (ch_dir[c]),
         .depth (ch_depth[c*CNT_W +: CNT_W]),
         .blen  (ch_blen[c*CNT_W +: CNT_W]),
         .evt   (word_evt[c]),
         .take  (take[c]),
         .req   (burst_req[c]),
         .err   (ch_err[c])
      );
   end

   bsched_rr #(.NUM_CH(NUM_CH)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (burst_req),
      .adv   (issue),
      .sel   (sel),
      .any   (any)
   );

   assign issue = !busy_q && any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         gv_q   <= 1'b0;
         gidx_q <= '0;
      end else begin
         busy_q <= issue || (busy_q && !burst_done);
         gv_q   <= issue;
         if (issue) gidx_q <= sel;
      end
   end

   assign busy        = busy_q;
   assign grant_valid = gv_q;
   assign grant_idx   = gidx_q;

   // R6: a grant is only issued from an idle state
   assert_idle_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
      gv_q |-> !$past(busy_q));
   // R6: grant pulses never occur back to back
   assert_grant_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      gv_q |=> !gv_q);
   // R6: a grant always leaves a burst outstanding
   assert_grant_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      gv_q |-> busy_q);
endmodule

// File: tb/tb_burst_sched.sv
`timescale 1ns/1ps
module tb_burst_sched;
   localparam int NUM_CH = 4;
   localparam int CNT_W  = 6;
   localparam int IDX_W  = $clog2(NUM_CH);

   logic clk = 1'b0;
   logic rst_n;
   logic [NUM_CH-1:0] ch_en, ch_dir, word_evt, burst_req, ch_err;
   logic [NUM_CH*CNT_W-1:0] ch_depth, ch_blen;
   logic burst_done, grant_valid, busy;
   logic [IDX_W-1:0] grant_idx;

   always #2.5 clk = ~clk;

   burst_sched #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .ch_dir(ch_dir),
      .ch_depth(ch_depth), .ch_blen(ch_blen), .word_evt(word_evt),
      .burst_done(burst_done), .burst_req(burst_req), .grant_valid(grant_valid),
      .grant_idx(grant_idx), .busy(busy), .ch_err(ch_err));

   // live and pending configuration
   logic [NUM_CH-1:0] en_l = '0, dir_l = '0, en_n = '0, dir_n = '0;
   int dep_l [NUM_CH], bl_l [NUM_CH], dep_n [NUM_CH], bl_n [NUM_CH];

   always_comb begin
      ch_en  = en_l;
      ch_dir = dir_l;
      for (int c = 0; c < NUM_CH; c++) begin
         ch_depth[c*CNT_W +: CNT_W] = CNT_W'(dep_l[c]);
         ch_blen[c*CNT_W +: CNT_W]  = CNT_W'(bl_l[c]);
      end
   end

   // reference model state
   int m_cnt [NUM_CH];
   bit m_err [NUM_CH];
   bit m_busy, m_gv;
   int m_gidx, m_last;
   int gcnt [NUM_CH];
   int n_chk = 0, n_bad = 0;
   bit fin = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic bit req_f(int c);
      int room;
      if (!en_l[c] || bl_l[c] == 0) return 1'b0;
      if (dir_l[c] == 1'b0) begin
         room = (dep_l[c] > m_cnt[c]) ? dep_l[c] - m_cnt[c] : 0;
         return room >= bl_l[c];
      end
      return m_cnt[c] >= bl_l[c];
   endfunction

   function automatic logic [NUM_CH-1:0] reqv_f();
      logic [NUM_CH-1:0] r;
      for (int c = 0; c < NUM_CH; c++) r[c] = req_f(c);
      return r;
   endfunction

   function automatic int rr_f(int last, logic [NUM_CH-1:0] r);
      for (int k = 1; k <= NUM_CH; k++)
         if (r[(last + k) % NUM_CH]) return (last + k) % NUM_CH;
      return -1;
   endfunction

   // one cycle: check at negedge, drive, advance model, wait next negedge
   task automatic cyc(input logic [NUM_CH-1:0] ev, input bit dn);
      logic [NUM_CH-1:0] rq, ev_v;
      int sel, w;
      bit issue;
      rq = reqv_f();
      for (int c = 0; c < NUM_CH; c++) ev_v[c] = m_err[c];
      chk(burst_req == rq, "R1 R2 R4 R8 burst_req", int'(burst_req), int'(rq));
      chk(grant_valid == m_gv, "R6 grant_valid", int'(grant_valid), int'(m_gv));
      chk(busy == m_busy, "R6 busy", int'(busy), int'(m_busy));
      if (m_gv) chk(int'(grant_idx) == m_gidx, "R7 grant_idx", int'(grant_idx), m_gidx);
      chk(ch_err == ev_v, "R3 R5 R8 ch_err", int'(ch_err), int'(ev_v));
      if (grant_valid) gcnt[grant_idx]++;
      en_l = en_n; dir_l = dir_n;
      for (int c = 0; c < NUM_CH; c++) begin dep_l[c] = dep_n[c]; bl_l[c] = bl_n[c]; end
      word_evt = ev; burst_done = dn;
      rq = reqv_f();
      issue = !m_busy && rq != '0;
      sel = issue ? rr_f(m_last, rq) : -1;
      for (int c = 0; c < NUM_CH; c++) begin
         if (!en_l[c]) begin
            m_cnt[c] = 0; m_err[c] = 0;
         end else if (dir_l[c] == 1'b0) begin
            w = m_cnt[c] + ((sel == c) ? bl_l[c] : 0);
            if (ev[c]) begin if (w == 0) m_err[c] = 1; else w--; end
            m_cnt[c] = w;
         end else begin
            w = m_cnt[c] - ((sel == c) ? bl_l[c] : 0);
            if (ev[c]) begin if (w >= dep_l[c]) m_err[c] = 1; else w++; end
            m_cnt[c] = w;
         end
      end
      m_busy = issue || (m_busy && !dn);
      m_gv = issue;
      if (issue) begin m_gidx = sel; m_last = sel; end
      @(negedge clk);
   endtask

   task automatic set_ch(int c, bit en, bit dir, int dep, int bl);
      en_n[c] = en; dir_n[c] = dir; dep_n[c] = dep; bl_n[c] = bl;
   endtask

   task automatic all_off();
      for (int c = 0; c < NUM_CH; c++) en_n[c] = 1'b0;
      cyc('0, m_busy);
      while (m_busy) cyc('0, 1'b1);
      cyc('0, 1'b0);
      for (int c = 0; c < NUM_CH; c++) gcnt[c] = 0;
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!fin) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         summary();
      end
   end

   initial begin
      for (int c = 0; c < NUM_CH; c++) begin
         dep_l[c] = 0; bl_l[c] = 0; dep_n[c] = 0; bl_n[c] = 0;
         m_cnt[c] = 0; m_err[c] = 0; gcnt[c] = 0;
      end
      m_busy = 0; m_gv = 0; m_gidx = 0; m_last = NUM_CH - 1;
      void'($urandom(32'd4711));
      rst_n = 1'b0; word_evt = '0; burst_done = 1'b0;
      repeat (3) @(negedge clk);
      // R11: reset state while held
      chk(burst_req == '0 && grant_valid == 0 && busy == 0 && ch_err == '0,
          "R11 reset outputs", int'({burst_req, grant_valid, busy, ch_err}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      cyc('0, 1'b0);

      // R7: all four playback channels eligible at once
      for (int c = 0; c < NUM_CH; c++) set_ch(c, 1, 0, 8, 4);
      begin
         int order [$];
         for (int i = 0; i < 24 && order.size() < 6; i++) begin
            if (grant_valid) order.push_back(int'(grant_idx));
            cyc('0, m_busy);
         end
         for (int i = 0; i < 6 && i < order.size(); i++)
            chk(order[i] == (i % NUM_CH), "R7 round-robin order", order[i], i % NUM_CH);
         chk(order.size() == 6, "R7 grant count", order.size(), 6);
      end
      all_off();

      // R3: playback pulse at empty count sets the sticky error
      set_ch(0, 1, 0, 8, 0);
      cyc('0, 0);
      cyc(4'b0001, 0);
      cyc('0, 0);
      chk(ch_err[0] == 1'b1, "R3 underflow error", int'(ch_err[0]), 1);
      chk(burst_req[0] == 1'b0, "R3 no request at blen 0", int'(burst_req[0]), 0);
      en_n[0] = 1'b0;
      cyc('0, 0);
      cyc('0, 0);
      chk(ch_err[0] == 1'b0, "R8 error cleared on disable", int'(ch_err[0]), 0);
      all_off();

      // R5: capture pulses beyond depth 3 set the error; R4 request at threshold
      set_ch(1, 1, 1, 3, 8);
      cyc('0, 0);
      for (int i = 0; i < 4; i++) cyc(4'b0010, 0);
      cyc('0, 0);
      chk(ch_err[1] == 1'b1, "R5 capture overflow error", int'(ch_err[1]), 1);
      all_off();
      set_ch(2, 1, 1, 20, 3);
      cyc('0, 0);
      cyc(4'b0100, 0); cyc(4'b0100, 0);
      chk(burst_req[2] == 1'b0, "R4 below threshold", int'(burst_req[2]), 0);
      cyc(4'b0100, 0);
      chk(burst_req[2] == 1'b1, "R4 at threshold", int'(burst_req[2]), 1);
      cyc('0, 0);
      chk(grant_valid && grant_idx == 2, "R6 grant one cycle after request",
          int'(grant_valid), 1);
      all_off();

      // R9: programmed depth 24 over a real 16-word FIFO, no drain
      set_ch(0, 1, 0, 24, 8);
      for (int i = 0; i < 16; i++) cyc('0, m_busy);
      chk(gcnt[0] == 3, "R9 bursts issued", gcnt[0], 3);
      chk(gcnt[0] * 8 > 16, "R9 real FIFO overrun", gcnt[0] * 8, 24);
      all_off();

      // R10: programmed depth 8 under a real 16-word FIFO
      set_ch(0, 1, 0, 8, 8);
      for (int i = 0; i < 16; i++) cyc('0, m_busy);
      chk(gcnt[0] == 1, "R10 bursts issued", gcnt[0], 1);
      chk(burst_req[0] == 1'b0 && (16 - gcnt[0] * 8) >= 8, "R10 withheld with room",
          int'(burst_req[0]), 0);
      all_off();

      // random mixed traffic
      set_ch(0, 1, 0, 16, 8);
      set_ch(1, 1, 0, 12, 4);
      set_ch(2, 1, 1, 20, 4);
      set_ch(3, 1, 1, 30, 6);
      for (int i = 0; i < 4000; i++) begin
         logic [NUM_CH-1:0] ev;
         for (int c = 0; c < NUM_CH; c++) ev[c] = ($urandom % 4) == 0;
         if (($urandom % 100) == 0) begin
            int c = $urandom % NUM_CH;
            en_n[c] = ~en_n[c];
         end
         cyc(ev, m_busy && ($urandom % 2));
      end
      fin = 1;
      summary();
   end
endmodule